// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Status Unit

This block watches every pin of two 32-pin GPIO ports and records transitions in sticky status registers. Each pin goes through a two-flop synchroniser, and a third flop holds the previous synchronised sample. A rising edge on a pin whose rising enable is set latches a bit in that port's rising-status register. A falling edge on a pin whose falling enable is set latches a bit in a separate falling-status register. Software clears bits by writing ones to a write-only clear register, and one such write clears the chosen bits in both status registers of that port.

Software reaches the registers through a simple memory-mapped interface. A request is a one-cycle pulse of `req_i`, with `we_i` choosing between write and read. A write takes effect at the clock edge that samples it. A read returns its data one cycle later, marked by `rvalid_o`. A small control state machine sequences the read side. It has two states: `BUS_IDLE` (no read data pending) and `BUS_RESP` (read data on `rdata_o`). It has four transitions. BUS_IDLE→BUS_RESP on a read request. BUS_RESP→BUS_RESP on a back-to-back read. BUS_RESP→BUS_IDLE when no read follows. BUS_IDLE→BUS_IDLE otherwise.

One interrupt line, `irq_o`, is the OR of every status bit of both ports. It stays high until software has cleared every set bit.

Top module: `gpio_eirq_top`

## Requirements
- R1: With bit n of a port's rising enable set, a 0→1 change of that port's pin n sets bit n of its rising-status register. The change is applied to `pin_i` before clock edge k, and the bit reads 1 from edge k+2. Bit n always maps to pin n (port p uses `pin_i[32p+n]`).
- R2: With bit n of the falling enable set, a 1→0 change of pin n sets bit n of the falling-status register, with the same timing as R1.
- R3: A set status bit stays set, whatever the pin does, until a clear write names it.
- R4: A write to a port's clear register clears, for every 1 bit n of the write data, bit n in both of that port's status registers. Bits written 0 leave both status bits unchanged.
- R5: If a clear write for bit n and an enabled edge event on pin n fall on the same clock edge, the status bit ends up 1.
- R6: The rising and falling enable registers are read/write and reset to 0. An enable bit of 0 stops its status bit from being set. Clearing an enable bit does not clear a status bit that is already set.
- R7: After reset, all status and enable registers read 0, and `irq_o` and `rvalid_o` are 0.
- R8: `irq_o` is 1 exactly when at least one status bit of either port is 1. It falls only after a clear write.
- R9: A read request sampled at edge k gives `rvalid_o`=1 and `rdata_o` in the cycle after edge k. Back-to-back reads give `rvalid_o` on consecutive cycles, and `rvalid_o` is 0 after a cycle with no read.
- R10: Register map (byte address on `addr_i`, port p base = 0x84 + 0x20·p). Rising status is at base+0x0, falling status at base+0x4, clear at base+0x8, rising enable at base+0xC and falling enable at base+0x10. Port 0 therefore uses 0x84/0x88/0x8C/0x90/0x94, and port 1 uses 0xA4/0xA8/0xAC/0xB0/0xB4. Any other address reads 0.
- R11: Reads of a clear register return 0. Writes to a status register change nothing.
- R12: A pin that stays at a level after its transition does not set its bit again once the bit is cleared. One transition gives exactly one event.
- R13: Edges and writes for one port never change the other port's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 64 | Asynchronous pin levels, port p pin n at bit 32p+n |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while rvalid_o is 1 |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Combined edge interrupt |

## Verification
The in-RTL assertions check the per-cycle rules on every cycle. A status bit rises only from an enabled event, and an event always wins over a clear. A bit falls only where a clear named it. A synchronised edge never pulses twice in a row. Read data follows each read request by exactly one cycle and never appears without one. A clear register always reads 0, and the interrupt drops only after a write. The bench's scenarios cover the behaviour that depends on sequences or on exact values. These are the bit-to-pin and address mapping, the latency from pin to status, and the stickiness of a bit while its pin stays high. They also cover the exact edge on which a set beats a clear, the fact that writes to status registers are ignored, and the independence of the two ports.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

    // Register-interface sequencing states
    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // Address layout: every port owns the same five registers
    localparam int unsigned PORT_BASE     = 32'h84;
    localparam int unsigned PORT_STRIDE   = 32'h20;
    localparam int unsigned OFF_STAT_RISE = 32'h00;
    localparam int unsigned OFF_STAT_FALL = 32'h04;
    localparam int unsigned OFF_CLEAR     = 32'h08;
    localparam int unsigned OFF_EN_RISE   = 32'h0C;
    localparam int unsigned OFF_EN_FALL   = 32'h10;

endpackage

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    localparam int unsigned CHAIN = SYNC_N + 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // [SYNC_N-1:0] synchroniser, [SYNC_N] previous synchronised sample
        logic [CHAIN-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN-2:0], pin_i[i]};
            end
        end

        assign rise_o[i] =  chain_q[SYNC_N-1] & ~chain_q[SYNC_N];
        assign fall_o[i] = ~chain_q[SYNC_N-1] &  chain_q[SYNC_N];
    end

    // R12
    rise_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & $past(rise_o)) == '0));

    // R12
    fall_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fall_o & $past(fall_o)) == '0));

endmodule

// File: rtl/gpio_eirq_bank.sv
module gpio_eirq_bank #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_evt_i,
    input  logic [WIDTH-1:0] fall_evt_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic             en_rise_we_i,
    input  logic             en_fall_we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] stat_rise_o,
    output logic [WIDTH-1:0] stat_fall_o,
    output logic [WIDTH-1:0] en_rise_o,
    output logic [WIDTH-1:0] en_fall_o,
    output logic             pend_o
);

    logic [WIDTH-1:0] stat_rise_q, stat_fall_q;
    logic [WIDTH-1:0] en_rise_q, en_fall_q;
    logic [WIDTH-1:0] set_rise, set_fall;

    assign set_rise = rise_evt_i & en_rise_q;
    assign set_fall = fall_evt_i & en_fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_rise_q <= '0;
            stat_fall_q <= '0;
            en_rise_q   <= '0;
            en_fall_q   <= '0;
        end else begin
            // set has priority over clear
            stat_rise_q <= (stat_rise_q & ~clr_i) | set_rise;
            stat_fall_q <= (stat_fall_q & ~clr_i) | set_fall;
            if (en_rise_we_i) en_rise_q <= wdata_i;
            if (en_fall_we_i) en_fall_q <= wdata_i;
        end
    end

    assign stat_rise_o = stat_rise_q;
    assign stat_fall_o = stat_fall_q;
    assign en_rise_o   = en_rise_q;
    assign en_fall_o   = en_fall_q;
    assign pend_o      = |{stat_rise_q, stat_fall_q};

    // R6
    rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rise_q & ~$past(stat_rise_q) & ~$past(en_rise_q)) == '0));

    // R6
    fall_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_fall_q & ~$past(stat_fall_q) & ~$past(en_fall_q)) == '0));

    // R5
    rise_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(rise_evt_i & en_rise_q) & ~stat_rise_q) == '0));

    // R5
    fall_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fall_evt_i & en_fall_q) & ~stat_fall_q) == '0));

    // R3
    rise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_rise_q) & ~stat_rise_q & ~$past(clr_i)) == '0));

    // R3
    fall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(stat_fall_q) & ~stat_fall_q & ~$past(clr_i)) == '0));

    // R4
    clear_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_i & ~(rise_evt_i & en_rise_q)) & stat_rise_q) == '0));

endmodule

// File: rtl/gpio_eirq_regif.sv
module gpio_eirq_regif
    import gpio_eirq_pkg::*;
#(
    parameter int unsigned NPORT = 2,
    parameter int unsigned WIDTH = 32,
    parameter int unsigned AW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [WIDTH-1:0]       wdata_i,
    output logic [WIDTH-1:0]       rdata_o,
    output logic                   rvalid_o,
    input  logic [NPORT*WIDTH-1:0] stat_rise_i,
    input  logic [NPORT*WIDTH-1:0] stat_fall_i,
    input  logic [NPORT*WIDTH-1:0] en_rise_i,
    input  logic [NPORT*WIDTH-1:0] en_fall_i,
    output logic [NPORT*WIDTH-1:0] clr_o,
    output logic [NPORT-1:0]       en_rise_we_o,
    output logic [NPORT-1:0]       en_fall_we_o
);

    function automatic logic [AW-1:0] reg_addr(int unsigned port, int unsigned off);
        return AW'(PORT_BASE + port * PORT_STRIDE + off);
    endfunction

    bus_state_e       state_q, state_d;
    logic [WIDTH-1:0] rdata_q;
    logic [WIDTH-1:0] rd_mux;
    logic             rd_req, wr_req, rd_is_clear;

    assign rd_req = req_i & ~we_i;
    assign wr_req = req_i &  we_i;

    // Address decode and read multiplexer
    always_comb begin
        rd_mux       = '0;
        rd_is_clear  = 1'b0;
        clr_o        = '0;
        en_rise_we_o = '0;
        en_fall_we_o = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (addr_i == reg_addr(p, OFF_STAT_RISE)) begin
                rd_mux = stat_rise_i[p*WIDTH +: WIDTH];
            end
            if (addr_i == reg_addr(p, OFF_STAT_FALL)) begin
                rd_mux = stat_fall_i[p*WIDTH +: WIDTH];
            end
            if (addr_i == reg_addr(p, OFF_CLEAR)) begin
                rd_is_clear = 1'b1;
                if (wr_req) clr_o[p*WIDTH +: WIDTH] = wdata_i;
            end
            if (addr_i == reg_addr(p, OFF_EN_RISE)) begin
                rd_mux          = en_rise_i[p*WIDTH +: WIDTH];
                en_rise_we_o[p] = wr_req;
            end
            if (addr_i == reg_addr(p, OFF_EN_FALL)) begin
                rd_mux          = en_fall_i[p*WIDTH +: WIDTH];
                en_fall_we_o[p] = wr_req;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_mux;
        end
    end

    // Outputs
    always_comb begin
        rvalid_o = 1'b0;
        rdata_o  = '0;
        unique case (state_q)
            BUS_IDLE: rvalid_o = 1'b0;
            BUS_RESP: begin
                rvalid_o = 1'b1;
                rdata_o  = rdata_q;
            end
            default:  rvalid_o = 1'b0;
        endcase
    end

    // R9
    read_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid_o);

    // R9
    no_valid_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rvalid_o);

    // R11
    clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_is_clear) |=> (rdata_o == '0));

endmodule

// File: rtl/gpio_eirq_top.sv
module gpio_eirq_top #(
    parameter int unsigned NPORT  = 2,
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned AW     = 8,
    parameter int unsigned SYNC_N = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT*WIDTH-1:0] pin_i,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [WIDTH-1:0]       wdata_i,
    output logic [WIDTH-1:0]       rdata_o,
    output logic                   rvalid_o,
    output logic                   irq_o
);

    localparam int unsigned NPIN = NPORT * WIDTH;

    logic [NPIN-1:0]  rise_evt, fall_evt;
    logic [NPIN-1:0]  stat_rise, stat_fall, en_rise, en_fall, clr;
    logic [NPORT-1:0] en_rise_we, en_fall_we, pend;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_eirq_edge #(
            .WIDTH  (WIDTH),
            .SYNC_N (SYNC_N)
        ) edge_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[p*WIDTH +: WIDTH]),
            .rise_o (rise_evt[p*WIDTH +: WIDTH]),
            .fall_o (fall_evt[p*WIDTH +: WIDTH])
        );

        gpio_eirq_bank #(
            .WIDTH (WIDTH)
        ) bank_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .rise_evt_i   (rise_evt[p*WIDTH +: WIDTH]),
            .fall_evt_i   (fall_evt[p*WIDTH +: WIDTH]),
            .clr_i        (clr[p*WIDTH +: WIDTH]),
            .en_rise_we_i (en_rise_we[p]),
            .en_fall_we_i (en_fall_we[p]),
            .wdata_i      (wdata_i),
            .stat_rise_o  (stat_rise[p*WIDTH +: WIDTH]),
            .stat_fall_o  (stat_fall[p*WIDTH +: WIDTH]),
            .en_rise_o    (en_rise[p*WIDTH +: WIDTH]),
            .en_fall_o    (en_fall[p*WIDTH +: WIDTH]),
            .pend_o       (pend[p])
        );
    end

    gpio_eirq_regif #(
        .NPORT (NPORT),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) regif_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .we_i         (we_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .rvalid_o     (rvalid_o),
        .stat_rise_i  (stat_rise),
        .stat_fall_i  (stat_fall),
        .en_rise_i    (en_rise),
        .en_fall_i    (en_fall),
        .clr_o        (clr),
        .en_rise_we_o (en_rise_we),
        .en_fall_we_o (en_fall_we)
    );

    assign irq_o = |pend;

    // R8
    irq_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_o) && !irq_o) |-> $past(req_i && we_i));

    // R8
    irq_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(irq_o) && irq_o) |-> $past(|{rise_evt, fall_evt}));

endmodule

// File: tb/gpio_eirq_top_tb_top.sv
module gpio_eirq_top_tb_top;

    localparam int NP = 2;
    localparam int W  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*W-1:0] pins = '0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata_o;
    logic          rvalid_o;
    logic          irq_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gpio_eirq_top dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pins),
        .req_i    (req),
        .we_i     (we),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o),
        .irq_o    (irq_o)
    );

    // ---------------- reference model ----------------
    logic [NP*W-1:0] h1, h2, h3;   // pin samples 1, 2, 3 edges back
    logic [31:0] m_rise [NP];
    logic [31:0] m_fall [NP];
    logic [31:0] m_ren  [NP];
    logic [31:0] m_fen  [NP];
    logic [31:0] m_rdata;
    logic        m_rvalid;

    function automatic logic [7:0] base_of(int p);
        return 8'(32'h84 + 32'h20 * p);
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] v = '0;
        for (int p = 0; p < NP; p++) begin
            if (a == base_of(p))         v = m_rise[p];
            if (a == base_of(p) + 8'h04) v = m_fall[p];
            if (a == base_of(p) + 8'h0C) v = m_ren[p];
            if (a == base_of(p) + 8'h10) v = m_fen[p];
        end
        return v;
    endfunction

    function automatic logic [31:0] clr_of(int p);
        return (req && we && addr == base_of(p) + 8'h08) ? wdata : 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 <= '0; h2 <= '0; h3 <= '0;
            m_rdata <= '0; m_rvalid <= 1'b0;
            for (int p = 0; p < NP; p++) begin
                m_rise[p] <= '0; m_fall[p] <= '0;
                m_ren[p]  <= '0; m_fen[p]  <= '0;
            end
        end else begin
            h1 <= pins; h2 <= h1; h3 <= h2;
            m_rvalid <= req && !we;
            if (req && !we) m_rdata <= model_read(addr);
            for (int p = 0; p < NP; p++) begin
                m_rise[p] <= (m_rise[p] & ~clr_of(p)) |
                             (h2[p*W +: W] & ~h3[p*W +: W] & m_ren[p]);
                m_fall[p] <= (m_fall[p] & ~clr_of(p)) |
                             (~h2[p*W +: W] & h3[p*W +: W] & m_fen[p]);
                if (req && we && addr == base_of(p) + 8'h0C) m_ren[p] <= wdata;
                if (req && we && addr == base_of(p) + 8'h10) m_fen[p] <= wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 irq vs model", 32'(irq_o),
                32'(|{m_rise[0], m_rise[1], m_fall[0], m_fall[1]}));
            chk("R9 rvalid vs model", 32'(rvalid_o), 32'(m_rvalid));
            if (m_rvalid) chk("R9 rdata vs model", rdata_o, m_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        d = rdata_o;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(tag, d, exp);
    endtask

    task automatic set_pin(input int idx, input logic v);
        @(negedge clk);
        pins[idx] = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    // ---------------- scenarios ----------------
    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R7 reset state
        chk("R7 irq after reset", 32'(irq_o), 0);
        chk("R7 rvalid after reset", 32'(rvalid_o), 0);
        read_chk("R7 rise status p0", 8'h84, 0);
        read_chk("R7 fall status p0", 8'h88, 0);
        read_chk("R7 rise enable p0", 8'h90, 0);
        read_chk("R7 fall enable p1", 8'hB4, 0);

        // R10 / R6 enable register access
        bus_write(8'h90, 32'h8000_0001);
        read_chk("R10 rise enable p0 readback", 8'h90, 32'h8000_0001);

        // R1 rising edges on pins 0, 31 (enabled) and 5 (not enabled)
        set_pin(0, 1'b1); set_pin(31, 1'b1); set_pin(5, 1'b1);
        wait_cyc(5);
        read_chk("R1 rise status p0", 8'h84, 32'h8000_0001);
        read_chk("R2 fall status p0 without fall enable", 8'h88, 0);
        chk("R8 irq set", 32'(irq_o), 1);

        // R11 writes to status ignored, clear reads 0
        bus_write(8'h84, 32'hFFFF_FFFF);
        bus_write(8'h88, 32'hFFFF_FFFF);
        read_chk("R11 rise status after write", 8'h84, 32'h8000_0001);
        read_chk("R11 fall status after write", 8'h88, 0);
        read_chk("R11 clear reads zero", 8'h8C, 0);

        // R3 sticky, R4 zero write changes nothing
        wait_cyc(20);
        bus_write(8'h8C, 32'h0);
        read_chk("R3 R4 rise status still set", 8'h84, 32'h8000_0001);

        // R4 / R12 clear bit 0, pin stays high, no re-set
        bus_write(8'h8C, 32'h1);
        wait_cyc(10);
        read_chk("R12 no re-set on steady pin", 8'h84, 32'h8000_0000);

        // R2 falling edges
        bus_write(8'h94, 32'hFFFF_FFFF);
        set_pin(0, 1'b0);
        wait_cyc(5);
        read_chk("R2 fall bit0", 8'h88, 32'h0000_0001);
        set_pin(5, 1'b0);
        wait_cyc(5);
        read_chk("R2 fall bit5", 8'h88, 32'h0000_0021);
        set_pin(31, 1'b0);
        wait_cyc(5);
        read_chk("R2 fall bit31", 8'h88, 32'h8000_0021);

        // R4 one clear write hits both registers
        bus_write(8'h8C, 32'h8000_0000);
        read_chk("R4 rise bit31 cleared", 8'h84, 0);
        read_chk("R4 fall bit31 cleared", 8'h88, 32'h0000_0021);

        // R5 set beats clear on the same edge
        bus_write(8'h90, 32'hFFFF_FFFF);
        set_pin(1, 1'b1);
        wait_cyc(5);
        set_pin(1, 1'b0);
        wait_cyc(5);
        read_chk("R5 setup rise", 8'h84, 32'h0000_0002);
        read_chk("R5 setup fall", 8'h88, 32'h0000_0023);
        @(negedge clk);
        pins[1] = 1'b1;           // sampled at edge j, event at edge j+2
        @(negedge clk);
        bus_write(8'h8C, 32'h2);  // sampled at edge j+2
        wait_cyc(3);
        read_chk("R5 rise kept by same-edge event", 8'h84, 32'h0000_0002);
        read_chk("R5 fall cleared", 8'h88, 32'h0000_0021);

        // R13 port 1 independent
        bus_write(8'hB0, 32'h0000_0080);
        set_pin(39, 1'b1);
        wait_cyc(5);
        read_chk("R13 p1 rise status", 8'hA4, 32'h0000_0080);
        read_chk("R13 p0 rise unchanged", 8'h84, 32'h0000_0002);
        read_chk("R13 p0 fall unchanged", 8'h88, 32'h0000_0021);

        // R6 disabling keeps existing bit, blocks new ones
        bus_write(8'hB0, 32'h0);
        read_chk("R6 p1 rise kept after disable", 8'hA4, 32'h0000_0080);
        set_pin(39, 1'b0);
        wait_cyc(5);
        read_chk("R6 p1 fall blocked", 8'hA8, 0);
        set_pin(39, 1'b1);
        wait_cyc(5);
        bus_write(8'hAC, 32'h80);
        read_chk("R6 p1 rise not re-set while disabled", 8'hA4, 0);

        // R8 irq follows all bits across ports
        bus_write(8'hB0, 32'h0000_0080);
        set_pin(39, 1'b0);
        set_pin(39, 1'b1);
        wait_cyc(5);
        bus_write(8'h8C, 32'hFFFF_FFFF);
        chk("R8 irq held by p1 bit", 32'(irq_o), 1);
        bus_write(8'hAC, 32'hFFFF_FFFF);
        chk("R8 irq low when all clear", 32'(irq_o), 0);

        // R10 unmapped addresses
        read_chk("R10 unmapped 0x00", 8'h00, 0);
        read_chk("R10 unmapped 0x98", 8'h98, 0);

        // R9 back-to-back reads
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 8'h90;
        @(negedge clk);
        chk("R9 first valid", 32'(rvalid_o), 1);
        chk("R9 first data", rdata_o, 32'hFFFF_FFFF);
        addr = 8'hB0;
        @(negedge clk);
        req = 1'b0;
        chk("R9 second valid", 32'(rvalid_o), 1);
        chk("R9 second data", rdata_o, 32'h0000_0080);
        @(negedge clk);
        chk("R9 valid drops", 32'(rvalid_o), 0);

        wait_cyc(3);
        finish_run();
    end

endmodule